// File: doc/BRIEF.md
# Serial Memory Protection and Command Decoder

This block sits behind the bit-level receiver of a two-wire serial slave that fronts a 512-byte nonvolatile memory. The memory is seen as two 256-byte pages, and each page is split into a lower and an upper 128-byte block, which gives four blocks in all. The decoder takes whole bytes from the receiver, together with bus START/STOP events and the master's acknowledge bits on read transfers. For every byte the master sends, it decides whether the slave drives ACK or leaves NACK. It also keeps the page selection, the per-block write-protect bits and the byte address pointer.

Writes are staged in a row buffer. After a STOP that closes a properly acknowledged write, the buffer drains to the storage array as a burst of write strobes. An external timer then ends the busy window. Reads produce one request per byte, carrying the full 9-bit address to the storage array.

The first byte of a transfer is the select byte. Its upper nibble is a type code, bits 3:1 are a select address, and bit 0 is the read flag. Protection and page commands are broadcast, so they ignore the select address. Status queries about protection and page are answered by ACK or NACK alone.

Top module: `prot_cmd_decoder`

## Requirements
- R1: Select type 1010 (memory) and type 0011 (temperature registers) are ACKed only when select bits 3:1 equal `addrPins`. Every type other than 1010, 0011 and 0110 is NACKed. An accepted temperature select pulses `tsSelect`.
- R2: A temperature select is NACKed while `hvPresent` is high.
- R3: Under type 0110 with read flag 0, bits 3:1 set protection on one block: 001 selects block 0, 100 block 1, 101 block 2 and 000 block 3. The command is ACKed and takes effect only with `hvPresent` high, whatever the value of `addrPins`. Without `hvPresent` it is NACKed and changes nothing. The block index is page*2 + address bit 7.
- R4: Under type 0110 with read flag 0, code 011 clears all four protect bits at once. It needs `hvPresent`, and is NACKed without it.
- R5: Under type 0110 with read flag 0, code 110 selects page 0 and code 111 selects page 1, with or without `hvPresent`. With read flag 1, code 110 is ACKed when page 0 is selected and NACKed when page 1 is selected. The page is 0 after reset.
- R6: With read flag 1, a block code (same mapping as R3) is ACKed if that block is unprotected and NACKed if it is protected. All other 0110 codes are reserved and NACKed: 010 for writes, and 010, 011 and 111 for reads.
- R7: A data byte whose target lies in a protected block is NACKed. It is not buffered and does not advance the pointer.
- R8: A write takes up to 16 data bytes, and the 17th is NACKed. After each accepted byte the pointer advances in its low 4 bits only, wrapping inside a 16-byte row.
- R9: A STOP ends a write cycle only when the last data byte was ACKed. In that case `wrBusy` rises on the cycle after the STOP, and each buffered byte gets one `memWe` strobe at its own address. `wrBusy` falls on the first cycle after a `writeDone` that arrives once the burst is done. Any other STOP discards the buffer.
- R10: While `wrBusy` is high, memory selects are NACKed and temperature selects are still ACKed.
- R11: A memory read select produces `rdReq` with `rdAddr` = {page, pointer}. Each master ACK (`mstAck`=1) produces the next address, wrapping from 0xFF to 0x00 within the page. A master NACK ends the read, and no further requests follow.
- R12: `ackValid` and `ackOut` (1 = ACK) appear on the cycle after the `rxValid` that carried the byte. No ACK decision is made outside a transfer, and none is made before reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startEvt | input | 1 | START or repeated START seen on the bus |
| stopEvt | input | 1 | STOP seen on the bus |
| rxValid | input | 1 | A byte from the master is complete |
| rxByte | input | 8 | The received byte |
| mstAckValid | input | 1 | Master acknowledge bit after a byte sent by the slave |
| mstAck | input | 1 | 1 = master ACK (continue), 0 = master NACK |
| addrPins | input | 3 | Select address strapped on the pins |
| hvPresent | input | 1 | High voltage detected on address pin 0 |
| writeDone | input | 1 | Write-cycle timer has expired |
| ackValid | output | 1 | ACK decision valid for the last received byte |
| ackOut | output | 1 | 1 = drive ACK, 0 = NACK |
| tsSelect | output | 1 | Temperature register access accepted |
| rdReq | output | 1 | Request for the next read byte |
| rdAddr | output | 9 | Read address {page, byte} |
| memWe | output | 1 | Array write strobe |
| memAddr | output | 9 | Array write address |
| memWdata | output | 8 | Array write data |
| wrBusy | output | 1 | Write burst or write cycle in progress |

## Verification
The hardest situation to reach is a write cycle that is busy while other traffic arrives. A memory select must then be refused while a temperature select is still accepted, and the burst must land on addresses that wrapped inside a 16-byte row. The stimulus reaches this state with a directed write that starts at row offset 0x0E. It issues both kinds of select before pulsing `writeDone`. A 17-byte write and a write to a protected block follow; both end without a write cycle. Random page writes of random length at random pages and offsets are then compared byte by byte against a bench shadow memory. Random select bytes, with random high-voltage state, are checked against a bench model of the protection and page state.

// File: rtl/prot_cmd_pkg.sv
package prot_cmd_pkg;

  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_CMD  = 4'b0110;
  localparam logic [3:0] TYPE_TEMP = 4'b0011;

  localparam logic [2:0] CODE_CLEAR = 3'b011;
  localparam logic [2:0] CODE_PG0   = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_MADDR,
    ST_MDATA,
    ST_MREAD,
    ST_SKIP
  } seqState_t;

  typedef struct packed {
    logic       loadPtr;
    logic       rowStep;
    logic       rdIssue;
    logic       bufPush;
    logic       bufClear;
    logic       commit;
    logic       protSet;
    logic [1:0] protIdx;
    logic       protClr;
    logic       pageSet;
    logic       pageVal;
    logic [7:0] data;
  } ctrlStrobe_t;

  // Non-binary block code in select bits 3:1: {valid, index}
  function automatic logic [2:0] blkDecode(input logic [2:0] code);
    case (code)
      3'b001:  blkDecode = 3'b100;
      3'b100:  blkDecode = 3'b101;
      3'b101:  blkDecode = 3'b110;
      3'b000:  blkDecode = 3'b111;
      default: blkDecode = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/prot_cmd_ctrl.sv
module prot_cmd_ctrl
  import prot_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startEvt,
  input  logic        stopEvt,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        mstAckValid,
  input  logic        mstAck,
  input  logic [2:0]  addrPins,
  input  logic        hvPresent,
  input  logic [3:0]  protBits,
  input  logic        curPage,
  input  logic        targetProt,
  input  logic        bufFull,
  input  logic        bufEmpty,
  input  logic        busy,
  output logic        ackValid,
  output logic        ackOut,
  output logic        tsSelect,
  output ctrlStrobe_t stb
);

  seqState_t state, nextState;
  logic lastAcked, lastAckNext;
  logic ackNext, ackValNext, tsNext;

  logic [3:0] devType;
  logic [2:0] selAddr;
  logic       rwFlag;
  logic [2:0] blk;
  logic       addrMatch;

  assign devType   = rxByte[7:4];
  assign selAddr   = rxByte[3:1];
  assign rwFlag    = rxByte[0];
  assign blk       = blkDecode(selAddr);
  assign addrMatch = (selAddr == addrPins);

  always_comb begin
    stb         = '0;
    stb.data    = rxByte;
    nextState   = state;
    ackNext     = 1'b0;
    ackValNext  = 1'b0;
    tsNext      = 1'b0;
    lastAckNext = lastAcked;
    if (startEvt) begin
      nextState    = ST_SEL;
      stb.bufClear = 1'b1;
      lastAckNext  = 1'b0;
    end else if (stopEvt) begin
      if (state == ST_MDATA && lastAcked && !bufEmpty) stb.commit = 1'b1;
      else stb.bufClear = 1'b1;
      nextState   = ST_IDLE;
      lastAckNext = 1'b0;
    end else if (rxValid) begin
      case (state)
        ST_SEL: begin
          ackValNext = 1'b1;
          nextState  = ST_SKIP;
          case (devType)
            TYPE_MEM: begin
              if (addrMatch && !busy) begin
                ackNext = 1'b1;
                if (rwFlag) begin
                  stb.rdIssue = 1'b1;
                  nextState   = ST_MREAD;
                end else begin
                  nextState = ST_MADDR;
                end
              end
            end
            TYPE_TEMP: begin
              if (addrMatch && !hvPresent) begin
                ackNext = 1'b1;
                tsNext  = 1'b1;
              end
            end
            TYPE_CMD: begin
              if (!rwFlag) begin
                if (blk[2]) begin
                  if (hvPresent) begin
                    ackNext     = 1'b1;
                    stb.protSet = 1'b1;
                    stb.protIdx = blk[1:0];
                  end
                end else if (selAddr == CODE_CLEAR) begin
                  if (hvPresent) begin
                    ackNext     = 1'b1;
                    stb.protClr = 1'b1;
                  end
                end else if (selAddr[2:1] == CODE_PG0[2:1]) begin
                  ackNext     = 1'b1;
                  stb.pageSet = 1'b1;
                  stb.pageVal = selAddr[0];
                end
              end else begin
                if (blk[2]) ackNext = !protBits[blk[1:0]];
                else if (selAddr == CODE_PG0) ackNext = !curPage;
              end
            end
            default: ;
          endcase
        end
        ST_MADDR: begin
          ackValNext  = 1'b1;
          ackNext     = 1'b1;
          stb.loadPtr = 1'b1;
          nextState   = ST_MDATA;
        end
        ST_MDATA: begin
          ackValNext = 1'b1;
          if (!targetProt && !bufFull) begin
            ackNext     = 1'b1;
            stb.bufPush = 1'b1;
            stb.rowStep = 1'b1;
            lastAckNext = 1'b1;
          end else begin
            lastAckNext = 1'b0;
          end
        end
        default: ;
      endcase
    end else if (mstAckValid && state == ST_MREAD) begin
      if (mstAck) stb.rdIssue = 1'b1;
      else nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lastAcked <= 1'b0;
      ackValid  <= 1'b0;
      ackOut    <= 1'b0;
      tsSelect  <= 1'b0;
    end else begin
      state     <= nextState;
      lastAcked <= lastAckNext;
      ackValid  <= ackValNext;
      ackOut    <= ackNext;
      tsSelect  <= tsNext;
    end
  end

endmodule

// File: rtl/prot_cmd_dpath.sv
module prot_cmd_dpath
  import prot_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter logic [3:0] PROT_INIT = 4'b0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t stb,
  input  logic        writeDone,
  output logic [3:0]  protBits,
  output logic        curPage,
  output logic        targetProt,
  output logic        bufFull,
  output logic        bufEmpty,
  output logic        busy,
  output logic        rdReq,
  output logic [8:0]  rdAddr,
  output logic        memWe,
  output logic [8:0]  memAddr,
  output logic [7:0]  memWdata
);

  localparam int ROW_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic [7:0]       ptr;
  logic [7:0]       bufData [BUF_DEPTH];
  logic [CNT_W-1:0] bufCount;
  logic [8:0]       baseAddr;
  logic             draining, waiting;
  logic [ROW_W-1:0] drainIdx;
  logic [CNT_W-1:0] drainCnt;
  logic [ROW_W-1:0] lastIdx;

  assign targetProt = protBits[{curPage, ptr[7]}];
  assign bufFull    = (bufCount == CNT_W'(BUF_DEPTH));
  assign bufEmpty   = (bufCount == '0);
  assign busy       = draining | waiting;
  assign lastIdx    = ROW_W'(drainCnt - CNT_W'(1));

  // Page, protection and address pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      protBits <= PROT_INIT;
      curPage  <= 1'b0;
      ptr      <= '0;
      rdReq    <= 1'b0;
      rdAddr   <= '0;
    end else begin
      if (stb.protClr) protBits <= '0;
      else if (stb.protSet) protBits[stb.protIdx] <= 1'b1;
      if (stb.pageSet) curPage <= stb.pageVal;
      rdReq <= stb.rdIssue;
      if (stb.loadPtr) begin
        ptr <= stb.data;
      end else if (stb.rowStep) begin
        ptr <= {ptr[7:ROW_W], ROW_W'(ptr[ROW_W-1:0] + 1'b1)};
      end else if (stb.rdIssue) begin
        rdAddr <= {curPage, ptr};
        ptr    <= ptr + 8'd1;
      end
    end
  end

  // Row buffer fill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bufCount <= '0;
      baseAddr <= '0;
    end else if (stb.commit || stb.bufClear) begin
      bufCount <= '0;
    end else if (stb.bufPush) begin
      if (bufEmpty) baseAddr <= {curPage, ptr};
      bufCount <= bufCount + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufPush && !bufFull) bufData[bufCount[ROW_W-1:0]] <= stb.data;
  end

  // Drain burst and busy window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      waiting  <= 1'b0;
      drainIdx <= '0;
      drainCnt <= '0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
    end else begin
      memWe <= 1'b0;
      if (stb.commit && !busy) begin
        draining <= 1'b1;
        drainIdx <= '0;
        drainCnt <= bufCount;
      end else if (draining) begin
        memWe    <= 1'b1;
        memAddr  <= {baseAddr[8:ROW_W], ROW_W'(baseAddr[ROW_W-1:0] + drainIdx)};
        memWdata <= bufData[drainIdx];
        drainIdx <= drainIdx + ROW_W'(1);
        if (drainIdx == lastIdx) begin
          draining <= 1'b0;
          waiting  <= 1'b1;
        end
      end else if (waiting && writeDone) begin
        waiting <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prot_cmd_decoder.sv
module prot_cmd_decoder
  import prot_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter logic [3:0] PROT_INIT = 4'b0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startEvt,
  input  logic       stopEvt,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       mstAckValid,
  input  logic       mstAck,
  input  logic [2:0] addrPins,
  input  logic       hvPresent,
  input  logic       writeDone,
  output logic       ackValid,
  output logic       ackOut,
  output logic       tsSelect,
  output logic       rdReq,
  output logic [8:0] rdAddr,
  output logic       memWe,
  output logic [8:0] memAddr,
  output logic [7:0] memWdata,
  output logic       wrBusy
);

  ctrlStrobe_t stb;
  logic [3:0]  protBits;
  logic        curPage, targetProt, bufFull, bufEmpty, busy;

  prot_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startEvt   (startEvt),
    .stopEvt    (stopEvt),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .mstAckValid(mstAckValid),
    .mstAck     (mstAck),
    .addrPins   (addrPins),
    .hvPresent  (hvPresent),
    .protBits   (protBits),
    .curPage    (curPage),
    .targetProt (targetProt),
    .bufFull    (bufFull),
    .bufEmpty   (bufEmpty),
    .busy       (busy),
    .ackValid   (ackValid),
    .ackOut     (ackOut),
    .tsSelect   (tsSelect),
    .stb        (stb)
  );

  prot_cmd_dpath #(
    .BUF_DEPTH(BUF_DEPTH),
    .PROT_INIT(PROT_INIT)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .writeDone (writeDone),
    .protBits  (protBits),
    .curPage   (curPage),
    .targetProt(targetProt),
    .bufFull   (bufFull),
    .bufEmpty  (bufEmpty),
    .busy      (busy),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

  assign wrBusy = busy;

endmodule

// File: rtl/prot_cmd_checker.sv
module prot_cmd_checker (
  input logic clk,
  input logic rst_n,
  input logic rxValid,
  input logic mstAckValid,
  input logic mstAck,
  input logic stopEvt,
  input logic writeDone,
  input logic ackValid,
  input logic rdReq,
  input logic memWe,
  input logic wrBusy
);

  // R12
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> $past(rxValid));

  // R11
  rd_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdReq |-> ($past(rxValid) || $past(mstAckValid && mstAck)));

  // R9
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrBusy) |-> $past(stopEvt));

  // R9
  we_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> wrBusy);

  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrBusy) |-> $past(writeDone));

endmodule

bind prot_cmd_decoder prot_cmd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rxValid    (rxValid),
  .mstAckValid(mstAckValid),
  .mstAck     (mstAck),
  .stopEvt    (stopEvt),
  .writeDone  (writeDone),
  .ackValid   (ackValid),
  .rdReq      (rdReq),
  .memWe      (memWe),
  .wrBusy     (wrBusy)
);

// File: tb/tb_prot_cmd_decoder.sv
module tb_prot_cmd_decoder;

  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startEvt = 0, stopEvt = 0, rxValid = 0, mstAckValid = 0, mstAck = 0;
  logic [7:0] rxByte = '0;
  logic hvPresent = 0, writeDone = 0;
  logic ackValid, ackOut, tsSelect, rdReq, memWe, wrBusy;
  logic [8:0] rdAddr, memAddr;
  logic [7:0] memWdata;

  int total = 0, bad = 0, weCount = 0;
  logic gotAckV, gotAck, gotRdV, gotTs, gotBusy;
  logic [8:0] gotRdA;
  logic [7:0] shadow [512];
  logic [7:0] expMem [512];
  logic [3:0] mProt = '0;
  logic mPage = 1'b0;

  always #4 clk = ~clk;

  prot_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .startEvt(startEvt), .stopEvt(stopEvt),
    .rxValid(rxValid), .rxByte(rxByte), .mstAckValid(mstAckValid), .mstAck(mstAck),
    .addrPins(PINS), .hvPresent(hvPresent), .writeDone(writeDone),
    .ackValid(ackValid), .ackOut(ackOut), .tsSelect(tsSelect), .rdReq(rdReq),
    .rdAddr(rdAddr), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .wrBusy(wrBusy)
  );

  always @(negedge clk) begin
    if (memWe) begin
      shadow[memAddr] <= memWdata;
      weCount <= weCount + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doStart();
    @(negedge clk); startEvt = 1;
    @(negedge clk); startEvt = 0;
  endtask

  task automatic doStop();
    @(negedge clk); stopEvt = 1;
    @(negedge clk); stopEvt = 0; gotBusy = wrBusy;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxByte = b; rxValid = 1;
    @(negedge clk); rxValid = 0;
    gotAckV = ackValid; gotAck = ackOut; gotRdV = rdReq; gotRdA = rdAddr; gotTs = tsSelect;
  endtask

  task automatic masterAck(input logic a);
    @(negedge clk); mstAckValid = 1; mstAck = a;
    @(negedge clk); mstAckValid = 0;
    gotRdV = rdReq; gotRdA = rdAddr;
  endtask

  task automatic expectAck(input logic [7:0] b, input logic exp, input string tag);
    sendByte(b);
    check(gotAckV && gotAck == exp, tag, {gotAckV, gotAck}, {1'b1, exp});
  endtask

  // Single select byte inside its own START/STOP
  task automatic cmd(input logic [7:0] b, input logic exp, input string tag);
    doStart();
    expectAck(b, exp, tag);
    doStop();
  endtask

  task automatic finishWrite(input string tag);
    repeat (20) tick();
    check(wrBusy == 1'b1, {tag, " busy held"}, wrBusy, 1);
    @(negedge clk); writeDone = 1;
    @(negedge clk); writeDone = 0;
    check(wrBusy == 1'b0, {tag, " busy release"}, wrBusy, 0);
  endtask

  function automatic logic [2:0] blkOf(input logic [2:0] c);
    case (c)
      3'b001: return 3'b100;
      3'b100: return 3'b101;
      3'b101: return 3'b110;
      3'b000: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic modelAck(input logic [7:0] b, input logic hv);
    logic [2:0] sa, bk;
    sa = b[3:1];
    bk = blkOf(sa);
    case (b[7:4])
      4'b1010: return sa == PINS;
      4'b0011: return sa == PINS && !hv;
      4'b0110:
        if (!b[0]) begin
          if (bk[2] || sa == 3'b011) return hv;
          return sa[2:1] == 2'b11;
        end else begin
          if (bk[2]) return !mProt[bk[1:0]];
          if (sa == 3'b110) return !mPage;
          return 1'b0;
        end
      default: return 1'b0;
    endcase
  endfunction

  task automatic modelApply(input logic [7:0] b, input logic hv);
    logic [2:0] bk;
    bk = blkOf(b[3:1]);
    if (b[7:4] == 4'b0110 && !b[0]) begin
      if (bk[2] && hv) mProt[bk[1:0]] = 1'b1;
      else if (b[3:1] == 3'b011 && hv) mProt = '0;
      else if (b[3:2] == 2'b11) mPage = b[1];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    logic [7:0] sel;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) begin shadow[i] = 8'h00; expMem[i] = 8'h00; end
    sel = {4'b1010, PINS, 1'b0};
    repeat (3) tick();
    // R12 reset state
    check(ackValid == 0 && wrBusy == 0 && memWe == 0 && rdReq == 0, "R12 reset outputs",
          {ackValid, wrBusy, memWe, rdReq}, 0);
    rst_n = 1;
    tick();
    // R12 byte outside a transfer gets no decision
    sendByte(8'h6D);
    check(gotAckV == 0, "R12 no ack outside transfer", gotAckV, 0);

    // R5 page 0 after reset
    cmd(8'h6D, 1'b1, "R5 page read after reset");
    // R6 block 0 unprotected
    cmd(8'h63, 1'b1, "R6 status block0 clear");
    // R3 set without high voltage refused
    cmd(8'h68, 1'b0, "R3 set without hv");
    cmd(8'h69, 1'b1, "R3 block1 still clear");
    hvPresent = 1;
    cmd(8'h68, 1'b1, "R3 set block1 with hv");
    cmd(8'h69, 1'b0, "R6 status block1 set");
    cmd(8'h63, 1'b1, "R6 status block0 unaffected");
    // R2 / R1 temperature select
    cmd({4'b0011, PINS, 1'b0}, 1'b0, "R2 temp select with hv");
    hvPresent = 0;
    doStart(); sendByte({4'b0011, PINS, 1'b0});
    check(gotAck && gotTs, "R1 temp select ack", {gotAck, gotTs}, 3);
    doStop();
    cmd({4'b0011, ~PINS, 1'b0}, 1'b0, "R1 temp mismatch");
    cmd({4'b1010, ~PINS, 1'b1}, 1'b0, "R1 mem mismatch");
    cmd(8'h5A, 1'b0, "R1 unknown type");

    // R8 row wrap write from 0x0E
    w0 = weCount;
    doStart(); expectAck(sel, 1, "R1 mem select"); expectAck(8'h0E, 1, "R8 addr");
    expectAck(8'hA1, 1, "R8 d0"); expectAck(8'hA2, 1, "R8 d1"); expectAck(8'hA3, 1, "R8 d2");
    doStop();
    check(gotBusy == 1, "R9 busy after stop", gotBusy, 1);
    // R10 during busy
    cmd(sel, 1'b0, "R10 mem select while busy");
    cmd({4'b0011, PINS, 1'b0}, 1'b1, "R10 temp select while busy");
    finishWrite("R9");
    check(weCount - w0 == 3, "R9 strobe count", weCount - w0, 3);
    check(shadow[9'h00E] == 8'hA1 && shadow[9'h00F] == 8'hA2 && shadow[9'h000] == 8'hA3,
          "R8 row wrap data", shadow[9'h000], 8'hA3);

    // R7 protected block
    doStart(); expectAck(sel, 1, "R7 select"); expectAck(8'h90, 1, "R7 addr");
    expectAck(8'h55, 0, "R7 protected data");
    doStop();
    check(gotBusy == 0, "R9 no cycle after nack", gotBusy, 0);
    doStart(); sendByte({4'b1010, PINS, 1'b1});
    check(gotRdV && gotRdA == 9'h090, "R7 pointer held", gotRdA, 9'h090);
    masterAck(1'b0);
    doStop();

    // R8 seventeenth byte
    doStart(); expectAck(sel, 1, "R8 select"); expectAck(8'h20, 1, "R8 addr");
    for (int i = 0; i < 16; i++) expectAck(8'h10 + 8'(i), 1, "R8 byte within limit");
    expectAck(8'hEE, 0, "R8 17th byte");
    doStop();
    check(gotBusy == 0, "R9 stop after nack discards", gotBusy, 0);
    w0 = weCount;
    doStart(); expectAck(sel, 1, "R8 select"); expectAck(8'h30, 1, "R8 addr");
    for (int i = 0; i < 16; i++) expectAck(8'h40 + 8'(i), 1, "R8 full row");
    doStop();
    check(gotBusy == 1, "R9 full row busy", gotBusy, 1);
    finishWrite("R9");
    check(weCount - w0 == 16, "R9 full row strobes", weCount - w0, 16);
    for (int i = 0; i < 16; i++)
      check(shadow[9'h030 + 9'(i)] == 8'h40 + 8'(i), "R9 full row data", shadow[9'h030 + 9'(i)], 8'h40 + i);

    // R11 sequential read wrap
    doStart(); expectAck(sel, 1, "R11 dummy write"); expectAck(8'hFE, 1, "R11 addr");
    doStart(); sendByte({4'b1010, PINS, 1'b1});
    check(gotAck && gotRdV && gotRdA == 9'h0FE, "R11 first read", gotRdA, 9'h0FE);
    masterAck(1'b1);
    check(gotRdV && gotRdA == 9'h0FF, "R11 second read", gotRdA, 9'h0FF);
    masterAck(1'b1);
    check(gotRdV && gotRdA == 9'h000, "R11 wrap read", gotRdA, 9'h000);
    masterAck(1'b0);
    check(gotRdV == 0, "R11 nack ends", gotRdV, 0);
    masterAck(1'b1);
    check(gotRdV == 0, "R11 no read after end", gotRdV, 0);
    doStop();

    // R5 page 1
    cmd(8'h6E, 1'b1, "R5 select page1");
    cmd(8'h6D, 1'b0, "R5 page read page1");
    doStart(); sendByte({4'b1010, PINS, 1'b1});
    check(gotRdV && gotRdA[8] == 1'b1, "R5 read uses page1", gotRdA, 9'h100);
    masterAck(1'b0); doStop();
    cmd(8'h6C, 1'b1, "R5 select page0");

    // R4 clear all
    cmd(8'h66, 1'b0, "R4 clear without hv");
    hvPresent = 1;
    cmd(8'h62, 1'b1, "R3 set block0");
    cmd(8'h6A, 1'b1, "R3 set block2");
    cmd(8'h60, 1'b1, "R3 set block3");
    cmd(8'h61, 1'b0, "R6 status block3 set");
    cmd(8'h66, 1'b1, "R4 clear with hv");
    hvPresent = 0;
    cmd(8'h63, 1'b1, "R4 block0 cleared");
    cmd(8'h69, 1'b1, "R4 block1 cleared");
    cmd(8'h6B, 1'b1, "R4 block2 cleared");
    cmd(8'h61, 1'b1, "R4 block3 cleared");
    // R6 reserved
    cmd(8'h64, 1'b0, "R6 reserved write 010");
    cmd(8'h65, 1'b0, "R6 reserved read 010");
    cmd(8'h67, 1'b0, "R6 reserved read 011");
    cmd(8'h6F, 1'b0, "R6 reserved read 111");

    for (int i = 0; i < 512; i++) expMem[i] = shadow[i];

    // Random select bytes against the model (R1 R2 R3 R4 R5 R6)
    for (int it = 0; it < 300; it++) begin
      logic [7:0] b;
      logic hv, e;
      int k;
      k = $urandom % 4;
      b = 8'($urandom);
      if (k == 0) b[7:4] = 4'b0110;
      else if (k == 1) b[7:4] = 4'b0011;
      else if (k == 2) begin b[7:4] = 4'b1010; if ($urandom % 2) b[3:1] = PINS; end
      hv = 1'($urandom);
      hvPresent = hv;
      e = modelAck(b, hv);
      cmd(b, e, "R6 random select vs model");
      modelApply(b, hv);
    end

    // Random page writes (R8 R9)
    hvPresent = 1; cmd(8'h66, 1'b1, "R4 clear before random writes"); hvPresent = 0;
    mProt = '0;
    for (int it = 0; it < 24; it++) begin
      logic pg;
      logic [7:0] a, d;
      int len;
      pg = 1'($urandom);
      a = 8'($urandom);
      len = 1 + ($urandom % 16);
      cmd({4'b0110, 2'b11, pg, 1'b0}, 1'b1, "R5 random page select");
      doStart(); expectAck(sel, 1, "R8 random select"); expectAck(a, 1, "R8 random addr");
      for (int j = 0; j < len; j++) begin
        d = 8'($urandom);
        expectAck(d, 1, "R8 random data");
        expMem[{pg, a[7:4], 4'(a[3:0] + 4'(j))}] = d;
      end
      doStop();
      check(gotBusy == 1, "R9 random busy", gotBusy, 1);
      finishWrite("R9 random");
      for (int j = 0; j < 16; j++) begin
        logic [8:0] ad;
        ad = {pg, a[7:4], 4'(j)};
        check(shadow[ad] == expMem[ad], "R9 random data", shadow[ad], expMem[ad]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule